// File: doc/BRIEF.md
# Program Counter Sample Trace Buffer

This block records periodic snapshots of eight processor-core program counters into an on-chip first-in first-out trace store, for later collection by software. A single-cycle sample strobe takes all eight 18-bit counters at once. Each one is cut to its upper 16 bits, because its two low bits are always zero. The eight values are packed into one 128-bit entry, and the entry is appended to a 1024-deep buffer.

Software drains the buffer through two 64-bit data reads for each entry and a packed 32-bit status word. Reading the upper half only looks at the oldest entry. Reading the lower half finishes the access and retires the entry. Capture runs on its own and never waits for software, so samples may arrive while a drain is under way. Samples that arrive while the buffer is full are dropped, and a sticky overflow indicator records the loss until software acknowledges it.

Top module: `pc_trace_buf`

## Requirements
- R1: On an accepted sample, core k's counter bits [17:2] are stored in entry bits [127-16k : 112-16k] (core 0 most significant, core 7 least significant); counter bits [1:0] have no effect on the entry.
- R2: An upper read returns entry bits [127:64] (cores 0 to 3) of the oldest entry on `rd_data_o` in the following cycle and leaves the read pointer unchanged. A lower read returns bits [63:0] (cores 4 to 7) and advances the read pointer by one. When both are requested in one cycle, only the lower read takes place.
- R3: A data read while the buffer is empty returns zero and changes neither pointer nor the occupancy.
- R4: `status_o` is laid out LSB-0 as [31:22] next-write address, [21:12] next-read address, [11] full, [10] empty (mask 0x400), [9:0] entry count modulo 1024.
- R5: With 1024 entries stored, full is 1, empty is 0 and the count field reads 0.
- R6: A sample arriving while the buffer is full is discarded: the pointers and all stored entries are unchanged, and `overflow_o` becomes 1 in the next cycle.
- R7: `overflow_o` stays set until a status-read strobe clears it. A drop in the same cycle as the strobe leaves it set.
- R8: A sample and a lower read in the same cycle both take effect: each pointer advances and the count is unchanged. Both addresses wrap from 1023 to 0.
- R9: After reset both pointers and the count are 0, empty is 1, full is 0, `overflow_o` is 0 and `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 1 | Single-cycle strobe that captures all counters |
| pc_i | input | 144 | Core k's 18-bit counter at bits [18k+17 : 18k] |
| rd_upper_i | input | 1 | Read upper 64 bits of the oldest entry, no retire |
| rd_lower_i | input | 1 | Read lower 64 bits of the oldest entry and retire it |
| stat_rd_i | input | 1 | Status-read strobe; clears the overflow indicator |
| rd_data_o | output | 64 | Registered data of the last read |
| status_o | output | 32 | Packed pointers, flags and count |
| overflow_o | output | 1 | Sticky dropped-sample indicator |

## Verification
Packing is tried with a walking single bit through every bit of every core's counter. This separates a misplaced core slot, a swapped half and a failure to drop the two low bits. Filling to exactly 1024 and pushing beyond that shows the full and empty flags, the count that reads zero, and drops that leave the contents intact. A drain after the pointers have wrapped confirms that nothing was overwritten. Runs of combined sample and retire cycles, reads of an empty buffer, and a drop that coincides with a status read cover the simultaneous-access rules.

// File: rtl/pct_pkg.sv
package pct_pkg;
    localparam int unsigned PCT_CORES   = 8;
    localparam int unsigned PCT_PC_W    = 18;
    localparam int unsigned PCT_PC_DROP = 2;
    localparam int unsigned PCT_DEPTH   = 1024;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_UPPER = 2'd1,
        RD_LOWER = 2'd2
    } rd_op_e;
endpackage

// File: rtl/pct_pack.sv
module pct_pack #(
    parameter int unsigned CORES   = 8,
    parameter int unsigned PC_W    = 18,
    parameter int unsigned PC_DROP = 2,
    localparam int unsigned SLICE_W = PC_W - PC_DROP,
    localparam int unsigned ENTRY_W = CORES * SLICE_W
) (
    input  logic [CORES*PC_W-1:0] pc_i,
    output logic [ENTRY_W-1:0]    entry_o
);
    // Core 0 lands in the most significant slot, core CORES-1 in the least.
    for (genvar k = 0; k < CORES; k++) begin : g_slot
        assign entry_o[ENTRY_W-1-k*SLICE_W -: SLICE_W] = pc_i[k*PC_W+PC_DROP +: SLICE_W];
    end
endmodule

// File: rtl/pct_store.sv
module pct_store
    import pct_pkg::*;
#(
    parameter int unsigned ENTRY_W = 128,
    parameter int unsigned DEPTH   = 1024,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned HALF_W = ENTRY_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ENTRY_W-1:0] entry_i,
    input  rd_op_e            op_i,
    output logic [HALF_W-1:0] rd_data_o,
    output logic [AW-1:0]     wr_ptr_o,
    output logic [AW-1:0]     rd_ptr_o,
    output logic [AW:0]       occ_o,
    output logic              drop_o
);
    localparam logic [AW:0]   OCC_FULL = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] PTR_ONE  = AW'(1);

    typedef struct packed {
        logic [AW-1:0]     wr_ptr;
        logic [AW-1:0]     rd_ptr;
        logic [AW:0]       occ;
        logic [HALF_W-1:0] rd_data;
    } st_t;

    st_t st_q, st_d;

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [ENTRY_W-1:0] head;
    logic               is_full, is_empty, push_ok, pop_ok;

    always_comb begin
        head     = mem[st_q.rd_ptr];
        is_full  = (st_q.occ == OCC_FULL);
        is_empty = (st_q.occ == '0);
        push_ok  = push_i && !is_full;
        pop_ok   = (op_i == RD_LOWER) && !is_empty;

        st_d = st_q;
        if (push_ok) st_d.wr_ptr = st_q.wr_ptr + PTR_ONE;
        if (pop_ok)  st_d.rd_ptr = st_q.rd_ptr + PTR_ONE;
        case ({push_ok, pop_ok})
            2'b10:   st_d.occ = st_q.occ + 1'b1;
            2'b01:   st_d.occ = st_q.occ - 1'b1;
            default: st_d.occ = st_q.occ;
        endcase
        case (op_i)
            RD_UPPER: st_d.rd_data = is_empty ? '0 : head[ENTRY_W-1 -: HALF_W];
            RD_LOWER: st_d.rd_data = is_empty ? '0 : head[HALF_W-1:0];
            default:  st_d.rd_data = st_q.rd_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr_ptr] <= entry_i;
    end

    assign rd_data_o = st_q.rd_data;
    assign wr_ptr_o  = st_q.wr_ptr;
    assign rd_ptr_o  = st_q.rd_ptr;
    assign occ_o     = st_q.occ;
    assign drop_o    = push_i && is_full;

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ <= OCC_FULL); // R5
    AST_DROP_HOLDS_WRPTR: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && is_full) |=> $stable(st_q.wr_ptr)); // R6
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != RD_IDLE && is_empty) |=> (st_q.rd_data == '0 && $stable(st_q.rd_ptr))); // R3
    AST_UPPER_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == RD_UPPER) |=> $stable(st_q.rd_ptr)); // R2
    AST_LOWER_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == RD_LOWER && !is_empty) |=> (st_q.rd_ptr == $past(st_q.rd_ptr) + PTR_ONE)); // R2
    AST_BOTH_KEEP_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !is_full && op_i == RD_LOWER && !is_empty) |=> $stable(st_q.occ)); // R8
endmodule

// File: rtl/pct_status.sv
module pct_status #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned SW   = 3*AW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] wr_ptr_i,
    input  logic [AW-1:0] rd_ptr_i,
    input  logic [AW:0]   occ_i,
    input  logic          drop_i,
    input  logic          clr_i,
    output logic [SW-1:0] status_o,
    output logic          overflow_o
);
    localparam logic [AW:0] OCC_FULL = (AW+1)'(DEPTH);

    typedef struct packed {
        logic ovf;
    } st_t;

    st_t  st_q, st_d;
    logic full, empty;

    always_comb begin
        full  = (occ_i == OCC_FULL);
        empty = (occ_i == '0);
        st_d  = st_q;
        if (drop_i)     st_d.ovf = 1'b1;
        else if (clr_i) st_d.ovf = 1'b0;
        // Most significant field first: write addr, read addr, full, empty, count.
        status_o = {wr_ptr_i, rd_ptr_i, full, empty, occ_i[AW-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overflow_o = st_q.ovf;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[AW] && status_o[AW+1])); // R4
    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> overflow_o); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !clr_i) |=> overflow_o); // R7
    AST_CLR_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !drop_i) |=> !overflow_o); // R7
endmodule

// File: rtl/pc_trace_buf.sv
module pc_trace_buf
    import pct_pkg::*;
#(
    parameter int unsigned CORES   = PCT_CORES,
    parameter int unsigned PC_W    = PCT_PC_W,
    parameter int unsigned PC_DROP = PCT_PC_DROP,
    parameter int unsigned DEPTH   = PCT_DEPTH,
    localparam int unsigned SLICE_W = PC_W - PC_DROP,
    localparam int unsigned ENTRY_W = CORES * SLICE_W,
    localparam int unsigned HALF_W  = ENTRY_W / 2,
    localparam int unsigned AW      = $clog2(DEPTH),
    localparam int unsigned SW      = 3*AW + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_i,
    input  logic [CORES*PC_W-1:0] pc_i,
    input  logic                  rd_upper_i,
    input  logic                  rd_lower_i,
    input  logic                  stat_rd_i,
    output logic [HALF_W-1:0]     rd_data_o,
    output logic [SW-1:0]         status_o,
    output logic                  overflow_o
);
    logic [ENTRY_W-1:0] entry;
    logic [AW-1:0]      wr_ptr, rd_ptr;
    logic [AW:0]        occ;
    logic               drop;
    rd_op_e             op;

    initial begin
        assert ((DEPTH & (DEPTH - 1)) == 0) else $error("DEPTH must be a power of two");
    end

    always_comb begin
        if (rd_lower_i)      op = RD_LOWER;
        else if (rd_upper_i) op = RD_UPPER;
        else                 op = RD_IDLE;
    end

    pct_pack #(.CORES(CORES), .PC_W(PC_W), .PC_DROP(PC_DROP)) u_pack (
        .pc_i    (pc_i),
        .entry_o (entry)
    );

    pct_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (sample_i),
        .entry_i   (entry),
        .op_i      (op),
        .rd_data_o (rd_data_o),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .occ_o     (occ),
        .drop_o    (drop)
    );

    pct_status #(.DEPTH(DEPTH)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ptr_i   (wr_ptr),
        .rd_ptr_i   (rd_ptr),
        .occ_i      (occ),
        .drop_i     (drop),
        .clr_i      (stat_rd_i),
        .status_o   (status_o),
        .overflow_o (overflow_o)
    );
endmodule

// File: tb/pc_trace_buf_tb.sv
module pc_trace_buf_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sample_i = 1'b0;
    logic [143:0] pc_i = '0;
    logic         rd_upper_i = 1'b0;
    logic         rd_lower_i = 1'b0;
    logic         stat_rd_i = 1'b0;
    logic [63:0]  rd_data_o;
    logic [31:0]  status_o;
    logic         overflow_o;

    int checks = 0;
    int errors = 0;

    logic [127:0] mq[$];
    int           m_wr = 0, m_rd = 0;
    logic         m_ovf = 1'b0;
    logic [63:0]  m_data = '0;

    always #5 clk = ~clk;

    pc_trace_buf u_dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .pc_i(pc_i),
        .rd_upper_i(rd_upper_i), .rd_lower_i(rd_lower_i), .stat_rd_i(stat_rd_i),
        .rd_data_o(rd_data_o), .status_o(status_o), .overflow_o(overflow_o)
    );

    function automatic logic [127:0] pack_ref(input logic [143:0] p);
        logic [127:0] e = '0;
        for (int k = 0; k < 8; k++) begin
            logic [17:0] c = p[k*18 +: 18];
            e[127-16*k -: 16] = c[17:2];
        end
        return e;
    endfunction

    function automatic logic [143:0] mk_pcs(input int seed);
        logic [143:0] p = '0;
        for (int k = 0; k < 8; k++)
            p[k*18 +: 18] = 18'((seed * 37 + k * 4099 + seed * k * 13 + 5) & 32'h3FFFF);
        return p;
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        int n = mq.size();
        return {10'(m_wr), 10'(m_rd), (n == 1024), (n == 0), 10'(n % 1024)};
    endfunction

    task automatic check_all(input string tag);
        chk(tag, "status", {32'h0, status_o}, {32'h0, exp_status()});
        chk(tag, "rd_data", rd_data_o, m_data);
        chk(tag, "overflow", {63'h0, overflow_o}, {63'h0, m_ovf});
    endtask

    // One clock of stimulus; inputs applied at a falling edge, results visible at the next.
    task automatic cyc(input logic push, input logic [143:0] p, input logic hi, input logic lo, input logic st);
        logic full, empty;
        sample_i = push; pc_i = p; rd_upper_i = hi; rd_lower_i = lo; stat_rd_i = st;
        full  = (mq.size() == 1024);
        empty = (mq.size() == 0);
        @(negedge clk);
        sample_i = 1'b0; rd_upper_i = 1'b0; rd_lower_i = 1'b0; stat_rd_i = 1'b0;
        if (lo)      m_data = empty ? 64'h0 : mq[0][63:0];
        else if (hi) m_data = empty ? 64'h0 : mq[0][127:64];
        if (lo && !empty) begin
            void'(mq.pop_front());
            m_rd = (m_rd + 1) % 1024;
        end
        if (push && !full) begin
            mq.push_back(pack_ref(p));
            m_wr = (m_wr + 1) % 1024;
        end
        if (push && full) m_ovf = 1'b1;
        else if (st)      m_ovf = 1'b0;
    endtask

    task automatic drain_check(input string tag);
        while (mq.size() > 0) begin
            cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
            check_all(tag);
            cyc(1'b0, '0, 1'b0, 1'b1, 1'b0);
            check_all(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state: only the empty bit (0x400) is set
        chk("R9", "status", {32'h0, status_o}, 64'h400);
        chk("R9", "rd_data", rd_data_o, 64'h0);
        chk("R9", "overflow", {63'h0, overflow_o}, 64'h0);

        // R3 reads on empty buffer return zero, pointers unmoved
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0); check_all("R3");
        cyc(1'b0, '0, 1'b0, 1'b1, 1'b0); check_all("R3");

        // R1 walking single bit through each core and each bit, incl. dropped low bits
        for (int k = 0; k < 8; k++)
            for (int b = 0; b < 18; b++) begin
                logic [143:0] p = '0;
                p[k*18 + b] = 1'b1;
                cyc(1'b1, p, 1'b0, 1'b0, 1'b0);
                check_all("R4");
            end
        // R2 upper read twice does not retire the head
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0); check_all("R2");
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0); check_all("R2");
        // R2 both strobes at once: lower access only
        cyc(1'b0, '0, 1'b1, 1'b1, 1'b0); check_all("R2");
        drain_check("R1");

        // R3 empty read with a same-cycle sample still returns zero
        cyc(1'b1, mk_pcs(7), 1'b0, 1'b1, 1'b0); check_all("R3");
        drain_check("R3");

        // R5 fill to 1024
        for (int i = 0; i < 1024; i++) cyc(1'b1, mk_pcs(i), 1'b0, 1'b0, 1'b0);
        check_all("R5");
        chk("R5", "count field", {54'h0, status_o[9:0]}, 64'h0);
        chk("R5", "full/empty", {62'h0, status_o[11:10]}, 64'h2);
        // R6 drop while full
        cyc(1'b1, mk_pcs(5000), 1'b0, 1'b0, 1'b0); check_all("R6");
        chk("R6", "overflow", {63'h0, overflow_o}, 64'h1);
        // R7 clear with status read, then drop coinciding with clear keeps it set
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b1); check_all("R7");
        chk("R7", "cleared", {63'h0, overflow_o}, 64'h0);
        cyc(1'b1, mk_pcs(5001), 1'b0, 1'b0, 1'b1); check_all("R7");
        chk("R7", "kept", {63'h0, overflow_o}, 64'h1);
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b0); check_all("R7");
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b1); check_all("R7");
        // R6 push with pop while full: push dropped, pop proceeds
        cyc(1'b1, mk_pcs(5002), 1'b0, 1'b1, 1'b0); check_all("R6");
        // R6 / R8 drain after pointer wrap: original contents intact
        drain_check("R6");

        // R8 simultaneous sample and retire over a steady level
        for (int i = 0; i < 4; i++) cyc(1'b1, mk_pcs(100 + i), 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 60; i++) begin
            cyc(1'b1, mk_pcs(200 + i), 1'b0, 1'b1, 1'b0);
            check_all("R8");
        end
        drain_check("R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule